// File: doc/BRIEF.md
# Bit-Rate Clock Enable Generator with Rate-Scaled Timeout

This block turns one fast system clock into the bit-time strobe of a token-passing network node and keeps a protocol timeout whose length follows the chosen bit rate. The system clock runs at the highest multiplied frequency, four times a 20 MHz reference by default. The reference itself, and the optional doubling or quadrupling of it, are modelled as a clock enable that fires once every one, two or four system cycles. A two-bit multiplier field picks that enable. A three-bit rate field then divides the enabled clock by a power of two from 8 to 128, which gives a single-cycle bit strobe.

The timeout counts bit strobes rather than system clocks. A timeout programmed as a number of bit times therefore lengthens by the same power-of-two factor as the divider. An idle-line period of 205 bit times lasts 41 µs at 5 Mbps and 1.31 ms at 156.25 kbps, with no separate scaling table. Line activity restarts the count. Expiry raises a sticky flag that only an explicit clear drops.

Top module: `rate_prescale_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `bit_en` and `tmo_expired` are low after that edge.
- R2: `mult_sel` sets the enabled-clock period in system cycles: 0 gives 4 (reference), 1 gives 2 (doubled), 2 gives 1 (quadrupled), and 3 is treated like 0.
- R3: `rate_sel` values 0, 1, 2, 3 and 4 divide the enabled clock by 8, 16, 32, 64 and 128. Values 5, 6 and 7 divide by 128, the slowest rate.
- R4: `bit_en` is a one-cycle pulse that repeats every (enabled-clock period × divider) system cycles while both selects are held.
- R5: A change of `mult_sel` or `rate_sel` restarts the divider. With the quadrupled clock, the first pulse after a change sampled at edge E comes N edges after E, where N is the new divider, and no pulse comes in between.
- R6: `tmo_expired` rises on the edge after the TMO_BITS-th `bit_en` pulse counted since the last restart.
- R7: `line_act` restarts the bit count and leaves `tmo_expired` unchanged.
- R8: `tmo_expired` stays high until `tmo_clr` is sampled high. `tmo_clr` drops the flag on that edge and also restarts the count.
- R9: With the quadrupled clock and a select change applied together with a restart, expiry is seen TMO_BITS × N + 2 edges later. The timeout therefore scales by the same factor as the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at the highest multiplied frequency |
| rst | input | 1 | Synchronous active-high reset |
| mult_sel | input | 2 | Clock multiplier select |
| rate_sel | input | 3 | Prescaler (data-rate) select |
| line_act | input | 1 | Line activity; restarts the timeout count |
| tmo_clr | input | 1 | Clears the expired flag and restarts the count |
| bit_en | output | 1 | Registered single-cycle bit-time strobe |
| tmo_expired | output | 1 | Registered sticky timeout-expired flag |

## Verification
The bench builds the block with TMO_BITS set to 6 and the other parameters at their defaults: a four-step multiplier and five divider steps from 8 to 128. The short timeout brings expiry into reach at every rate, including the slowest one at 512 system cycles per bit, so exact expiry edges can be checked at two dividers and the ratio between them compared. The default widths still cover every encoding of both selects, including the reserved multiplier code and the three rate codes above 4.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int unsigned MULT_SEL_W = 2;
  localparam int unsigned RATE_SEL_W = 3;

  typedef logic [MULT_SEL_W-1:0] mult_sel_t;
  typedef logic [RATE_SEL_W-1:0] rate_sel_t;

  // log2 of the clock multiplication, clamped to what the system clock allows
  function automatic int unsigned mult_shift(input mult_sel_t sel, input int unsigned max_log2);
    int unsigned s;
    case (sel)
      2'd1:    s = 1;
      2'd2:    s = 2;
      default: s = 0;
    endcase
    return (s > max_log2) ? max_log2 : s;
  endfunction

  // log2 of the divider; codes beyond the last step select the slowest rate
  function automatic int unsigned div_shift(input rate_sel_t sel, input int unsigned min_log2,
                                            input int unsigned steps);
    int unsigned idx;
    idx = int'(sel);
    return min_log2 + ((idx < steps) ? idx : steps - 1);
  endfunction
endpackage

// File: rtl/rpt_ref_enable.sv
module rpt_ref_enable #(
  parameter int unsigned MULT_LOG2_MAX = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  rpt_pkg::mult_sel_t  mult_sel,
  output logic                ref_en
);
  localparam int unsigned PH_W = (MULT_LOG2_MAX > 0) ? MULT_LOG2_MAX : 1;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  // enable period is 2^(MULT_LOG2_MAX - shift) system cycles
  always_comb begin
    mask   = PH_W'((32'd1 << (MULT_LOG2_MAX - rpt_pkg::mult_shift(mult_sel, MULT_LOG2_MAX))) - 32'd1);
    ref_en = ((phase_q & mask) == '0);
  end
endmodule

// File: rtl/rpt_bit_divider.sv
module rpt_bit_divider #(
  parameter int unsigned DIV_LOG2_MIN = 3,
  parameter int unsigned RATE_STEPS   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_en,
  input  logic               restart,
  input  rpt_pkg::rate_sel_t rate_sel,
  output logic               bit_en
);
  localparam int unsigned CNT_W = DIV_LOG2_MIN + RATE_STEPS - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;

  always_comb
    last_c = CNT_W'((32'd1 << rpt_pkg::div_shift(rate_sel, DIV_LOG2_MIN, RATE_STEPS)) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      bit_en <= 1'b0;
    end else if (ref_en) begin
      if (cnt_q == last_c) begin
        cnt_q  <= '0;
        bit_en <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        bit_en <= 1'b0;
      end
    end else begin
      bit_en <= 1'b0;
    end
  end
endmodule

// File: rtl/rpt_timeout.sv
module rpt_timeout #(
  parameter int unsigned TMO_BITS = 205
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic line_act,
  input  logic tmo_clr,
  output logic expired
);
  localparam int unsigned TC_W = $clog2(TMO_BITS + 1);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(TMO_BITS - 1);

  logic [TC_W-1:0] tcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q  <= '0;
      expired <= 1'b0;
    end else if (tmo_clr || line_act) begin
      tcnt_q <= '0;
      if (tmo_clr) expired <= 1'b0;
    end else if (bit_en) begin
      if (tcnt_q == TC_LAST) begin
        tcnt_q  <= '0;
        expired <= 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rate_prescale_timer.sv
module rate_prescale_timer #(
  parameter int unsigned MULT_LOG2_MAX = 2,
  parameter int unsigned DIV_LOG2_MIN  = 3,
  parameter int unsigned RATE_STEPS    = 5,
  parameter int unsigned TMO_BITS      = 205
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mult_sel,
  input  logic [2:0] rate_sel,
  input  logic       line_act,
  input  logic       tmo_clr,
  output logic       bit_en,
  output logic       tmo_expired
);
  localparam int unsigned CFG_W = rpt_pkg::MULT_SEL_W + rpt_pkg::RATE_SEL_W;

  logic [CFG_W-1:0] cfg_q;
  logic             restart;
  logic             ref_en;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= {mult_sel, rate_sel};
  end

  assign restart = ({mult_sel, rate_sel} != cfg_q);

  rpt_ref_enable #(.MULT_LOG2_MAX(MULT_LOG2_MAX)) u_ref (
    .clk(clk), .rst(rst), .mult_sel(mult_sel), .ref_en(ref_en)
  );

  rpt_bit_divider #(.DIV_LOG2_MIN(DIV_LOG2_MIN), .RATE_STEPS(RATE_STEPS)) u_div (
    .clk(clk), .rst(rst), .ref_en(ref_en), .restart(restart),
    .rate_sel(rate_sel), .bit_en(bit_en)
  );

  rpt_timeout #(.TMO_BITS(TMO_BITS)) u_tmo (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_act(line_act),
    .tmo_clr(tmo_clr), .expired(tmo_expired)
  );
endmodule

// File: rtl/rpt_checker.sv
module rpt_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mult_sel,
  input logic [2:0] rate_sel,
  input logic       line_act,
  input logic       tmo_clr,
  input logic       bit_en,
  input logic       tmo_expired
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!bit_en && !tmo_expired));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> !bit_en);

  assert_change_restarts_R5: assert property (@(posedge clk) disable iff (rst)
    ({mult_sel, rate_sel} != $past({mult_sel, rate_sel})) |=> !bit_en);

  assert_expiry_after_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_expired) |-> $past(bit_en));

  assert_activity_no_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    (line_act && !tmo_expired) |=> !tmo_expired);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (tmo_expired && !tmo_clr) |=> tmo_expired);

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
    tmo_clr |=> !tmo_expired);
endmodule

bind rate_prescale_timer rpt_checker u_rpt_checker (
  .clk(clk), .rst(rst), .mult_sel(mult_sel), .rate_sel(rate_sel),
  .line_act(line_act), .tmo_clr(tmo_clr), .bit_en(bit_en), .tmo_expired(tmo_expired)
);

// File: tb/rate_prescale_timer_tb.sv
module rate_prescale_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 6;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mult_sel = 2'd0;
  logic [2:0] rate_sel = 3'd0;
  logic       line_act = 1'b0;
  logic       tmo_clr = 1'b0;
  logic       bit_en;
  logic       tmo_expired;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_prescale_timer #(.TMO_BITS(TMO)) u_dut (
    .clk(clk), .rst(rst), .mult_sel(mult_sel), .rate_sel(rate_sel),
    .line_act(line_act), .tmo_clr(tmo_clr), .bit_en(bit_en), .tmo_expired(tmo_expired)
  );

  function automatic int mper(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 1 : 4;
  endfunction

  function automatic int ndiv(input logic [2:0] r);
    return (r <= 3'd4) ? (8 << r) : 128;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // behavioural reference, updated with the values present at each edge
  int   m_phase, m_dcnt, m_tcnt, mp, nd;
  logic m_bit, m_exp, sel_now;
  logic [4:0] m_prev;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_dcnt = 0; m_tcnt = 0; m_bit = 0; m_exp = 0; m_prev = '0;
    end else begin
      mp = mper(mult_sel);
      nd = ndiv(rate_sel);
      sel_now = ((m_phase % mp) == 0);
      if (tmo_clr || line_act) begin
        m_tcnt = 0;
        if (tmo_clr) m_exp = 0;
      end else if (m_bit) begin
        if (m_tcnt == TMO - 1) begin m_exp = 1; m_tcnt = 0; end
        else m_tcnt++;
      end
      if ({mult_sel, rate_sel} != m_prev) begin
        m_dcnt = 0; m_bit = 0;
      end else if (sel_now) begin
        if (m_dcnt == nd - 1) begin m_bit = 1; m_dcnt = 0; end
        else begin m_dcnt++; m_bit = 0; end
      end else begin
        m_bit = 0;
      end
      m_prev  = {mult_sel, rate_sel};
      m_phase = (m_phase + 1) % 4;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(bit_en == m_bit, "R4 bit_en vs model", int'(bit_en), int'(m_bit));
      check(tmo_expired == m_exp, "R6 tmo_expired vs model", int'(tmo_expired), int'(m_exp));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      finish_tb();
    end
  end

  task automatic wait_pulse();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (bit_en) return;
    end
  endtask

  task automatic measure(input logic [1:0] m, input logic [2:0] r, input int exp, input string req);
    int k;
    @(negedge clk);
    mult_sel = m; rate_sel = r;
    wait_pulse();
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      k++;
      if (bit_en) break;
    end
    check(k == exp, req, k, exp);
  endtask

  task automatic edges_to_expiry(input logic [2:0] r, output int k);
    @(negedge clk);
    rate_sel = r; line_act = 1'b1; tmo_clr = 1'b1;
    k = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      k++;
      line_act = 1'b0; tmo_clr = 1'b0;
      if (tmo_expired) break;
    end
  endtask

  initial begin
    int k, k8, k32;
    repeat (3) @(negedge clk);
    check(!bit_en && !tmo_expired, "R1 reset state", int'({bit_en, tmo_expired}), 0);
    rst = 1'b0;

    measure(2'd2, 3'd0, 8,   "R3 x4 div8 period");
    measure(2'd1, 3'd1, 32,  "R2 x2 div16 period");
    measure(2'd0, 3'd2, 128, "R2 x1 div32 period");
    measure(2'd3, 3'd0, 32,  "R2 reserved mult acts as x1");
    measure(2'd2, 3'd4, 128, "R3 div128 period");
    measure(2'd2, 3'd5, 128, "R3 code5 falls back to div128");
    measure(2'd2, 3'd7, 128, "R3 code7 falls back to div128");
    measure(2'd2, 3'd3, 64,  "R4 x4 div64 period");

    // R5: change mid-period, next pulse N+1 negedges later
    @(negedge clk); rate_sel = 3'd0;
    wait_pulse();
    repeat (3) @(negedge clk);
    rate_sel = 3'd1;
    k = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      k++;
      if (bit_en) break;
    end
    check(k == 17, "R5 restart on select change", k, 17);

    // R9 / R6: exact expiry edges at two dividers
    edges_to_expiry(3'd0, k8);
    check(k8 == TMO * 8 + 2, "R9 expiry edges div8", k8, TMO * 8 + 2);
    edges_to_expiry(3'd2, k32);
    check(k32 == TMO * 32 + 2, "R9 expiry edges div32", k32, TMO * 32 + 2);
    check((k32 - 2) == 4 * (k8 - 2), "R9 timeout ratio follows divider", k32 - 2, 4 * (k8 - 2));

    // R8 sticky, R7 activity leaves flag
    repeat (100) @(negedge clk);
    check(tmo_expired, "R8 flag sticky", int'(tmo_expired), 1);
    line_act = 1'b1; @(negedge clk); line_act = 1'b0;
    check(tmo_expired, "R7 activity keeps flag", int'(tmo_expired), 1);
    tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
    check(!tmo_expired, "R8 clear drops flag", int'(tmo_expired), 0);

    // R7: frequent activity prevents expiry
    rate_sel = 3'd0;
    for (int it = 0; it < 10; it++) begin
      @(negedge clk); line_act = 1'b1;
      @(negedge clk); line_act = 1'b0;
      repeat (28) @(negedge clk);
    end
    check(!tmo_expired, "R7 activity restarts count", int'(tmo_expired), 0);

    // R6 at the slowest rate with the reference clock
    @(negedge clk);
    mult_sel = 2'd0; rate_sel = 3'd4; tmo_clr = 1'b1;
    @(negedge clk); tmo_clr = 1'b0;
    repeat (2900) @(negedge clk);
    check(!tmo_expired, "R6 no early expiry slowest", int'(tmo_expired), 0);
    repeat (400) @(negedge clk);
    check(tmo_expired, "R6 expiry slowest rate", int'(tmo_expired), 1);

    // R1 again: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(!bit_en && !tmo_expired, "R1 reset mid-run", int'({bit_en, tmo_expired}), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    finish_tb();
  end
endmodule